// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Combiner

This block sits behind the analog stages of a nine-stage pipelined analog-to-digital converter. It turns their raw decisions into one corrected 10-bit sample on every clock. The first eight stages each resolve 1.5 bits and report a redundant two-bit code. The ninth stage is a single comparator that reports one bit. A stage reports its decision for a given sample one clock after the stage ahead of it. The block therefore holds the earlier decisions in per-stage delay lines until all nine decisions for that sample are present in the same cycle.

Once the decisions line up, the block adds the stage codes with overlapping weights. The low bit of one stage's code carries the same weight as the high bit of the next stage's code, so the redundancy is absorbed by the addition instead of being concatenated away. The sum is clamped to the output range and registered.

The block also folds an illegal stage code into the nearest legal one and latches an error indication. It raises a valid flag once the delay lines hold only post-reset decisions. Reset is synchronous and active high.

Top module: `adc_stage_combiner`

## Requirements
- R1: While `rst` is high at a rising edge, that edge leaves `code_o` at 0, `valid_o` at 0 and `err_o` at 0.
- R2: For one sample, stage k (k = 1..8, code on `stg_code_i[2k-1:2k-2]`) is presented k-1 cycles after stage 1, and the final bit is presented 8 cycles after stage 1. All nine are combined as one sample, with stage k carrying weight 2^(9-k).
- R3: The output code equals the sum over k of d_k·2^(9-k), plus the final bit. The stage codes decode as 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. The sum is clamped to 0..1023.
- R4: The result of a sample appears on `code_o` just after the rising edge that takes in its final bit, that is, the 9th rising edge counted from the edge that takes in its stage-1 code.
- R5: A stage code of 2'b11 is used as 2'b10 in the sum.
- R6: `err_o` goes high just after any rising edge (with `rst` low) that takes in a 2'b11 on any stage. It stays high until reset.
- R7: After reset is released, `valid_o` stays low through the first 8 rising edges. It goes high after the 9th and then stays high.
- R8: A new sample may start on every clock. Back-to-back samples do not disturb each other's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stg_code_i | input | 16 | Two-bit codes of stages 1..8, stage 1 in the low two bits |
| fin_bit_i | input | 1 | Final comparator decision |
| code_o | output | 10 | Corrected, registered sample code |
| valid_o | output | 1 | High once the delay lines have filled after reset |
| err_o | output | 1 | Sticky flag: an illegal stage code was seen |

## Verification
The bench builds the block with its default parameters: eight redundant stages and a 10-bit output. This gives delay lines from eight registers deep down to one, and a largest possible sum of 1021. At these defaults the clamp is never reached, so the bench pins that bound with an all-high sample. One-hot samples isolate the weight and the alignment of every single stage. A long stream of unrelated samples, later mixed with illegal codes, compares each cycle against a model that simply remembers the samples it sent. A second reset checks the fill timing a second time and the clearing of the error flag.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int DEC_W = 2;

    typedef enum logic [DEC_W-1:0] {
        DEC_LOW  = 2'b00,
        DEC_MID  = 2'b01,
        DEC_HIGH = 2'b10,
        DEC_BAD  = 2'b11
    } dec_e;

    typedef struct packed {
        logic [DEC_W-1:0] code;
        logic             bad;
    } dec_chk_t;

    // Fold an illegal decision onto the highest legal one and flag it.
    function automatic dec_chk_t check_dec(input logic [DEC_W-1:0] raw);
        dec_chk_t r;
        r.bad  = (raw == DEC_BAD);
        r.code = r.bad ? DEC_HIGH : raw;
        return r;
    endfunction

    function automatic int max_sum(input int n_stg);
        return (2 ** (n_stg + 2)) - 3;
    endfunction

endpackage

// File: rtl/stage_sanitizer.sv
module stage_sanitizer
    import adc_corr_pkg::*;
#(
    parameter int N_STG = 8
) (
    input  logic [N_STG*DEC_W-1:0] raw_i,
    output logic [N_STG*DEC_W-1:0] clean_o,
    output logic                   bad_o
);
    logic [N_STG-1:0] bad_vec;

    for (genvar k = 0; k < N_STG; k++) begin : g_chk
        dec_chk_t chk;
        assign chk = check_dec(raw_i[k*DEC_W +: DEC_W]);
        assign clean_o[k*DEC_W +: DEC_W] = chk.code;
        assign bad_vec[k] = chk.bad;
    end

    assign bad_o = |bad_vec;
endmodule

// File: rtl/stage_align.sv
module stage_align
    import adc_corr_pkg::*;
#(
    parameter int N_STG = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_STG*DEC_W-1:0] codes_i,
    input  logic                   fin_i,
    output logic [N_STG*DEC_W-1:0] codes_o,
    output logic                   fin_o
);
    // Stage k (0-based) arrives k cycles after stage 0, so it waits N_STG-k cycles.
    for (genvar k = 0; k < N_STG; k++) begin : g_line
        localparam int DEPTH = N_STG - k;
        logic [DEC_W-1:0] line_q [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
            end else begin
                line_q[0] <= codes_i[k*DEC_W +: DEC_W];
                for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
            end
        end

        assign codes_o[k*DEC_W +: DEC_W] = line_q[DEPTH-1];
    end

    assign fin_o = fin_i;
endmodule

// File: rtl/overlap_adder.sv
module overlap_adder
    import adc_corr_pkg::*;
#(
    parameter int N_STG = 8,
    parameter int OUT_W = 10
) (
    input  logic [N_STG*DEC_W-1:0] codes_i,
    input  logic                   fin_i,
    output logic [OUT_W-1:0]       sum_o
);
    localparam int SUM_W = (N_STG + 3 > OUT_W + 1) ? N_STG + 3 : OUT_W + 1;
    localparam logic [SUM_W-1:0] CLAMP = SUM_W'((2 ** OUT_W) - 1);

    logic [SUM_W-1:0] acc;

    always_comb begin
        acc = SUM_W'(fin_i);
        for (int k = 0; k < N_STG; k++) begin
            acc = acc + (SUM_W'(codes_i[k*DEC_W +: DEC_W]) << (N_STG - k));
        end
    end

    assign sum_o = (acc > CLAMP) ? CLAMP[OUT_W-1:0] : acc[OUT_W-1:0];
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
    parameter int FILL = 8
) (
    input  logic clk,
    input  logic rst,
    output logic valid_o
);
    localparam int CNT_W = $clog2(FILL + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILL);

    logic [CNT_W-1:0] cnt_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            vld_q <= 1'b0;
        end else begin
            if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            vld_q <= (cnt_q == LAST);
        end
    end

    assign valid_o = vld_q;

    p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> vld_q);
endmodule

// File: rtl/adc_stage_combiner.sv
module adc_stage_combiner
    import adc_corr_pkg::*;
#(
    parameter int N_STG = 8,
    parameter int OUT_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_STG*DEC_W-1:0] stg_code_i,
    input  logic                   fin_bit_i,
    output logic [OUT_W-1:0]       code_o,
    output logic                   valid_o,
    output logic                   err_o
);
    localparam int MAXV = max_sum(N_STG);

    logic [N_STG*DEC_W-1:0] clean_codes;
    logic [N_STG*DEC_W-1:0] lined_codes;
    logic                   lined_fin;
    logic                   bad_any;
    logic [OUT_W-1:0]       sum_c;
    logic [OUT_W-1:0]       code_q;
    logic                   err_q;

    stage_sanitizer #(.N_STG(N_STG)) u_sanitize (
        .raw_i   (stg_code_i),
        .clean_o (clean_codes),
        .bad_o   (bad_any)
    );

    stage_align #(.N_STG(N_STG)) u_align (
        .clk     (clk),
        .rst     (rst),
        .codes_i (clean_codes),
        .fin_i   (fin_bit_i),
        .codes_o (lined_codes),
        .fin_o   (lined_fin)
    );

    overlap_adder #(.N_STG(N_STG), .OUT_W(OUT_W)) u_add (
        .codes_i (lined_codes),
        .fin_i   (lined_fin),
        .sum_o   (sum_c)
    );

    fill_tracker #(.FILL(N_STG)) u_fill (
        .clk     (clk),
        .rst     (rst),
        .valid_o (valid_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            code_q <= sum_c;
            err_q  <= err_q | bad_any;
        end
    end

    assign code_o = code_q;
    assign err_o  = err_q;

    p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
        bad_any |=> err_o);
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        int'(code_o) <= MAXV);

    for (genvar k = 0; k < N_STG; k++) begin : g_legal
        p_legal_lined_r5: assert property (@(posedge clk) disable iff (rst)
            lined_codes[k*DEC_W +: DEC_W] != DEC_BAD);
    end
endmodule

// File: tb/adc_stage_combiner_bench.sv
`timescale 1ns/1ps
module adc_stage_combiner_bench;
    localparam int NS = 8;
    localparam int NSAMP = 320;
    localparam int ILL_FROM = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] stg_code = '0;
    logic        fin_bit = 1'b0;
    logic [9:0]  code;
    logic        valid;
    logic        err;

    int total = 0;
    int fails = 0;
    int sc [NSAMP][NS];
    int fb [NSAMP];
    string tg [NSAMP];
    bit exp_err = 0;

    always #2.5 clk = ~clk;

    adc_stage_combiner u_adc_stage_combiner (
        .clk        (clk),
        .rst        (rst),
        .stg_code_i (stg_code),
        .fin_bit_i  (fin_bit),
        .code_o     (code),
        .valid_o    (valid),
        .err_o      (err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int expect_val(input int s);
        int v = fb[s];
        for (int k = 0; k < NS; k++) begin
            int d = (sc[s][k] > 2) ? 2 : sc[s][k];
            v += d * (2 ** (NS - k));
        end
        return (v > 1023) ? 1023 : v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        stg_code = '0;
        fin_bit = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 code", int'(code), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 err", int'(err), 0);
        exp_err = 0;
        rst = 1'b0;
    endtask

    // Starts at the negedge where reset was released; drives cycle 0 at once.
    task automatic run_seq(input int base, input int n);
        bit pend = 0;
        for (int t = 0; t <= n + 8; t++) begin
            if (t > 0) begin
                int e = t - 1;
                chk("R7 valid", int'(valid), (e >= 8) ? 1 : 0);
                if (e >= 8) chk(tg[base + e - 8], int'(code), expect_val(base + e - 8));
                exp_err = exp_err | pend;
                pend = 0;
                chk("R6 err", int'(err), int'(exp_err));
            end
            for (int k = 0; k < NS; k++) begin
                int s = t - k;
                int c = (s >= 0 && s < n) ? sc[base + s][k] : 0;
                if (c == 3) pend = 1;
                stg_code[2*k +: 2] = 2'(c);
            end
            fin_bit = (t - 8 >= 0 && t - 8 < n) ? fb[base + t - 8][0] : 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int s = 0; s < NSAMP; s++) begin
            fb[s] = 0;
            tg[s] = "R8 stream";
            for (int k = 0; k < NS; k++) sc[s][k] = 0;
        end
        for (int k = 0; k < NS; k++) begin
            sc[1][k] = 2;
            sc[2][k] = 1;
            sc[12][k] = 2;
        end
        fb[1] = 1;
        tg[0] = "R3 zero";
        tg[1] = "R3 top bound";
        tg[2] = "R3 mid codes";
        for (int j = 0; j < NS; j++) begin
            sc[3 + j][j] = 1;
            tg[3 + j] = "R2 stage weight";
        end
        fb[11] = 1;
        tg[11] = "R2 final bit";
        tg[12] = "R4 latency";
        for (int s = 14; s < NSAMP; s++) begin
            for (int k = 0; k < NS; k++) sc[s][k] = int'($urandom % 3);
            fb[s] = int'($urandom % 2);
            if (s >= ILL_FROM && ($urandom % 4) == 0) begin
                sc[s][$urandom % NS] = 3;
                tg[s] = "R5 illegal fold";
            end
        end

        do_reset();
        run_seq(0, NSAMP);
        do_reset();
        run_seq(0, 16);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule